// File: doc/BRIEF.md
# Precise Exception Arbitration Unit

This block sits at the commit point of an in-order pipeline and decides, cycle by cycle, whether an exception is entered and which one. It watches the retiring instruction (its valid flag, address, sequential successor address and fault class), an idle indication for the execution units, five maskable interrupt lines and two nonmaskable lines. When it grants an exception, it emits a one-cycle flush together with the handler address. In the same cycle it captures a restart address and the old status word in two save registers, and it clears the interrupt-enable and recoverable bits of the live status word.

Faults raised by instructions are precise. Neither the faulting instruction nor anything younger completes. Trap and system-call instructions save the address that follows them rather than their own. Maskable interrupts are only taken at an instruction boundary, or at once when the pipeline is idle. A return-from-interrupt request copies the saved status back and redirects fetch to the saved restart address. A floating-point precision mode input is accepted, but every setting gives the precise behaviour.

Top module: `exc_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `status` equals RESET_STATUS (default 0x03), and `flush`, `take`, `save_pc` and `save_stat` are all zero. Status bit 0 is the interrupt enable (EE) and bit 1 is the recoverable bit (RI).
- R2: When several requests are present in one cycle, exactly one exception is granted. The order from highest to lowest is: system reset, machine check, exception of the retiring instruction, external, decrementer, system management, thermal, performance monitor.
- R3: A retiring instruction with `ret_cause` 1 (fault) or 4 (floating-point) is not committed (`commit`=0). It is taken with `save_pc` equal to its own `ret_pc`.
- R4: A retiring instruction with `ret_cause` 2 (trap) or 3 (system call) is taken with `save_pc` equal to its `ret_npc`.
- R5: A maskable interrupt is not taken while no instruction retires and the pipeline is busy. It is taken on the cycle a clean instruction retires; that instruction commits, and `save_pc` equals its `ret_npc`.
- R6: With no retiring instruction and `pipe_empty`=1, a pending enabled maskable interrupt is taken at once, and `save_pc` equals `resume_pc`.
- R7: Maskable lines are ignored while EE=0. A rising edge on `nmi_reset` or `nmi_mcheck` is taken whatever EE holds, and a line held high is taken only once.
- R8: On every exception entry, `save_stat` receives the previous `status`, and EE and RI read zero in the new `status`.
- R9: `take` and `flush` last one cycle. On entry, `fetch_pc` equals VEC_BASE + (`take_code` << VEC_SHIFT). The codes are: 1 reset, 2 machine check, 3 fault, 4 trap, 5 system call, 6 floating-point, 7 external, 8 decrementer, 9 system management, 10 thermal, 11 performance monitor.
- R10: `rfi` with no exception in that cycle raises `flush` without `take`. It sets `status` to the old `save_stat` and `fetch_pc` to `save_pc`.
- R11: Every `fp_mode` value gives the same precise result for a floating-point exception.
- R12: In the cycle right after a flush, the retire and `rfi` inputs are ignored. Nothing commits and no instruction exception or return is generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction is retiring this cycle |
| ret_pc | input | AW | Address of the retiring instruction |
| ret_npc | input | AW | Sequential successor address |
| ret_cause | input | 3 | 0 none, 1 fault, 2 trap, 3 system call, 4 floating-point |
| fp_mode | input | 2 | Floating-point precision mode, no effect on behaviour |
| pipe_empty | input | 1 | No instruction in the execution units |
| resume_pc | input | AW | Next address to run when the pipeline is idle |
| rfi | input | 1 | Return-from-interrupt request |
| irq_ext | input | 1 | External interrupt level |
| irq_dec | input | 1 | Decrementer interrupt level |
| irq_smi | input | 1 | System-management interrupt level |
| irq_therm | input | 1 | Thermal interrupt level |
| irq_perf | input | 1 | Performance-monitor interrupt level |
| nmi_reset | input | 1 | System reset request, edge-taken |
| nmi_mcheck | input | 1 | Machine check request, edge-taken |
| commit | output | 1 | Retiring instruction may update state |
| flush | output | 1 | One-cycle pipeline flush and redirect |
| take | output | 1 | One-cycle exception entry marker |
| take_code | output | 4 | Code of the exception taken |
| fetch_pc | output | AW | Redirect target: handler vector or restored address |
| save_pc | output | AW | Saved restart address |
| save_stat | output | SW | Saved status word |
| status | output | SW | Live status word |

## Verification
The bound checker checks several rules on every cycle: flushes last a single cycle, entry always clears EE and RI and saves the previous status, the handler address matches the code, maskable entries occur only with EE set, and faulting or post-flush instructions never commit. A return is also checked against the saved registers. Only the bench's scenarios can show that the arbitration order is right, that the restart address is chosen per cause (own address, successor or idle address), that a held interrupt is deferred until a boundary, and that a held nonmaskable line fires once.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [3:0] {
        EXC_NONE  = 4'd0,
        EXC_RESET = 4'd1,
        EXC_MCHK  = 4'd2,
        EXC_FAULT = 4'd3,
        EXC_TRAP  = 4'd4,
        EXC_SYSC  = 4'd5,
        EXC_FPE   = 4'd6,
        EXC_EXT   = 4'd7,
        EXC_DEC   = 4'd8,
        EXC_SMI   = 4'd9,
        EXC_THERM = 4'd10,
        EXC_PERF  = 4'd11
    } exc_code_e;

    typedef enum logic [2:0] {
        RC_NONE  = 3'd0,
        RC_FAULT = 3'd1,
        RC_TRAP  = 3'd2,
        RC_SYSC  = 3'd3,
        RC_FPE   = 3'd4
    } ret_cause_e;

    // request classes in priority order, index 0 highest
    localparam int NUM_CLASS = 8;
    localparam int CL_RESET  = 0;
    localparam int CL_MCHK   = 1;
    localparam int CL_INSTR  = 2;
    localparam int CL_EXT    = 3;
    localparam int CL_DEC    = 4;
    localparam int CL_SMI    = 5;
    localparam int CL_THERM  = 6;
    localparam int CL_PERF   = 7;

    localparam int ST_EE = 0;
    localparam int ST_RI = 1;

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // lower index wins; each slot is masked by everything above it
    for (genvar i = 0; i < N; i++) begin : g_slot
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
    import exc_pkg::*;
#(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  VEC_BASE  = '0,
    parameter int             VEC_SHIFT = 8
) (
    input  exc_code_e        code,
    output logic [AW-1:0]    vec
);
    localparam logic [AW-1:0] CODE_MASK = AW'(4'hF);

    assign vec = VEC_BASE + ((AW'(code) & CODE_MASK) << VEC_SHIFT);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int            AW           = 32,
    parameter int            SW           = 8,
    parameter logic [AW-1:0] VEC_BASE     = '0,
    parameter int            VEC_SHIFT    = 8,
    parameter logic [SW-1:0] RESET_STATUS = SW'(3)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_pc,
    input  logic [AW-1:0] ret_npc,
    input  logic [2:0]    ret_cause,
    input  logic [1:0]    fp_mode,
    input  logic          pipe_empty,
    input  logic [AW-1:0] resume_pc,
    input  logic          rfi,
    input  logic          irq_ext,
    input  logic          irq_dec,
    input  logic          irq_smi,
    input  logic          irq_therm,
    input  logic          irq_perf,
    input  logic          nmi_reset,
    input  logic          nmi_mcheck,
    output logic          commit,
    output logic          flush,
    output logic          take,
    output logic [3:0]    take_code,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] save_pc,
    output logic [SW-1:0] save_stat,
    output logic [SW-1:0] status
);
    localparam logic [SW-1:0] ENTRY_CLEAR = SW'((1 << ST_EE) | (1 << ST_RI));

    typedef struct packed {
        logic          flush;
        logic          take;
        exc_code_e     code;
        logic [AW-1:0] fetch_pc;
        logic [AW-1:0] save_pc;
        logic [SW-1:0] save_stat;
        logic [SW-1:0] status;
        logic [1:0]    nmi_prev;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CLASS-1:0] req, grant;
    logic                 any_req;
    exc_code_e            sel_code;
    logic [AW-1:0]        vec_addr;

    logic          ret_live, rfi_live, instr_exc, at_boundary, mask_ok;
    logic          fp_imprecise;
    exc_code_e     instr_code;
    logic [AW-1:0] instr_restart, async_restart, nmi_restart, sel_restart;

    exc_prio_pick #(.N(NUM_CLASS)) u_pick (
        .req   (req),
        .grant (grant),
        .any   (any_req)
    );

    exc_vec_gen #(.AW(AW), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)) u_vec (
        .code (sel_code),
        .vec  (vec_addr)
    );

    always_comb begin
        // the cycle after a flush belongs to squashed, younger work
        ret_live     = ret_valid && !st_q.flush;
        rfi_live     = rfi && !st_q.flush;
        instr_exc    = ret_live && (ret_cause != RC_NONE);
        fp_imprecise = |fp_mode;

        instr_code    = EXC_FAULT;
        instr_restart = ret_pc;
        case (ret_cause)
            RC_TRAP: begin
                instr_code    = EXC_TRAP;
                instr_restart = ret_npc;
            end
            RC_SYSC: begin
                instr_code    = EXC_SYSC;
                instr_restart = ret_npc;
            end
            RC_FPE: begin
                instr_code    = EXC_FPE;
                // imprecise modes are served exactly as the precise one
                instr_restart = fp_imprecise ? ret_pc : ret_pc;
            end
            default: begin
                instr_code    = EXC_FAULT;
                instr_restart = ret_pc;
            end
        endcase

        at_boundary   = ret_live ? !instr_exc : pipe_empty;
        mask_ok       = st_q.status[ST_EE] && at_boundary && !rfi_live && !st_q.flush;
        async_restart = ret_live ? ret_npc : resume_pc;
        nmi_restart   = ret_live ? ret_pc : resume_pc;

        req            = '0;
        req[CL_RESET]  = nmi_reset  && !st_q.nmi_prev[0];
        req[CL_MCHK]   = nmi_mcheck && !st_q.nmi_prev[1];
        req[CL_INSTR]  = instr_exc;
        req[CL_EXT]    = irq_ext   && mask_ok;
        req[CL_DEC]    = irq_dec   && mask_ok;
        req[CL_SMI]    = irq_smi   && mask_ok;
        req[CL_THERM]  = irq_therm && mask_ok;
        req[CL_PERF]   = irq_perf  && mask_ok;

        sel_code    = EXC_NONE;
        sel_restart = async_restart;
        for (int i = 0; i < NUM_CLASS; i++) begin
            if (grant[i]) begin
                case (i)
                    CL_RESET: begin sel_code = EXC_RESET; sel_restart = nmi_restart;   end
                    CL_MCHK:  begin sel_code = EXC_MCHK;  sel_restart = nmi_restart;   end
                    CL_INSTR: begin sel_code = instr_code; sel_restart = instr_restart; end
                    CL_EXT:   sel_code = EXC_EXT;
                    CL_DEC:   sel_code = EXC_DEC;
                    CL_SMI:   sel_code = EXC_SMI;
                    CL_THERM: sel_code = EXC_THERM;
                    default:  sel_code = EXC_PERF;
                endcase
            end
        end

        commit = ret_live && !instr_exc && !req[CL_RESET] && !req[CL_MCHK];

        st_d          = st_q;
        st_d.flush    = 1'b0;
        st_d.take     = 1'b0;
        st_d.nmi_prev = {nmi_mcheck, nmi_reset};

        if (any_req) begin
            st_d.flush     = 1'b1;
            st_d.take      = 1'b1;
            st_d.code      = sel_code;
            st_d.fetch_pc  = vec_addr;
            st_d.save_pc   = sel_restart;
            st_d.save_stat = st_q.status;
            st_d.status    = st_q.status & ~ENTRY_CLEAR;
        end else if (rfi_live) begin
            st_d.flush    = 1'b1;
            st_d.fetch_pc = st_q.save_pc;
            st_d.status   = st_q.save_stat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.code      <= EXC_NONE;
            st_q.status    <= RESET_STATUS;
            st_q.nmi_prev  <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush     = st_q.flush;
    assign take      = st_q.take;
    assign take_code = st_q.code;
    assign fetch_pc  = st_q.fetch_pc;
    assign save_pc   = st_q.save_pc;
    assign save_stat = st_q.save_stat;
    assign status    = st_q.status;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk #(
    parameter int            AW        = 32,
    parameter int            SW        = 8,
    parameter logic [AW-1:0] VEC_BASE  = '0,
    parameter int            VEC_SHIFT = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ret_valid,
    input logic [2:0]    ret_cause,
    input logic          rfi,
    input logic          nmi_reset,
    input logic          nmi_mcheck,
    input logic          commit,
    input logic          flush,
    input logic          take,
    input logic [3:0]    take_code,
    input logic [AW-1:0] fetch_pc,
    input logic [AW-1:0] save_pc,
    input logic [SW-1:0] save_stat,
    input logic [SW-1:0] status
);
    p_take_needs_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> flush);

    p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !nmi_reset && !nmi_mcheck) |=> !flush);

    p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (fetch_pc == VEC_BASE + (AW'(take_code) << VEC_SHIFT)));

    p_entry_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!status[0] && !status[1]));

    p_entry_saves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take) |-> (save_stat == $past(status)));

    p_mask_needs_ee_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_code >= 4'd7) |-> $past(status[0]));

    p_rfi_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi && !flush && !take) |=> ((flush && !take) ->
            (status == $past(save_stat) && fetch_pc == $past(save_pc))));

    p_no_commit_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_cause != 3'd0) |-> !commit);

    p_flush_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !commit);
endmodule

bind exc_arbiter exc_arbiter_chk #(
    .AW(AW), .SW(SW), .VEC_BASE(VEC_BASE), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_cause(ret_cause),
    .rfi(rfi), .nmi_reset(nmi_reset), .nmi_mcheck(nmi_mcheck),
    .commit(commit), .flush(flush), .take(take), .take_code(take_code),
    .fetch_pc(fetch_pc), .save_pc(save_pc), .save_stat(save_stat), .status(status)
);

// File: tb/exc_arbiter_test.sv
`timescale 1ns/1ps
module exc_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ret_valid, pipe_empty, rfi;
    logic [31:0] ret_pc, ret_npc, resume_pc;
    logic [2:0]  ret_cause;
    logic [1:0]  fp_mode;
    logic        irq_ext, irq_dec, irq_smi, irq_therm, irq_perf;
    logic        nmi_reset, nmi_mcheck;
    logic        commit, flush, take;
    logic [3:0]  take_code;
    logic [31:0] fetch_pc, save_pc;
    logic [7:0]  save_stat, status;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          tk;
        logic [3:0]  code;
        logic [31:0] fpc;
        logic [31:0] spc;
        logic [7:0]  sst;
        logic [7:0]  st;
        string       tag;
    } item_t;

    item_t exp_q[$];
    logic [7:0]  m_st, m_sst;
    logic [31:0] m_spc;

    always #2.5 clk = ~clk;

    exc_arbiter uut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_npc(ret_npc), .ret_cause(ret_cause), .fp_mode(fp_mode),
        .pipe_empty(pipe_empty), .resume_pc(resume_pc), .rfi(rfi),
        .irq_ext(irq_ext), .irq_dec(irq_dec), .irq_smi(irq_smi),
        .irq_therm(irq_therm), .irq_perf(irq_perf), .nmi_reset(nmi_reset),
        .nmi_mcheck(nmi_mcheck), .commit(commit), .flush(flush), .take(take),
        .take_code(take_code), .fetch_pc(fetch_pc), .save_pc(save_pc),
        .save_stat(save_stat), .status(status)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic idle();
        ret_valid = 0; ret_pc = 0; ret_npc = 0; ret_cause = 0; rfi = 0;
        pipe_empty = 0; irq_ext = 0; irq_dec = 0; irq_smi = 0;
        irq_therm = 0; irq_perf = 0; nmi_reset = 0; nmi_mcheck = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_take(input logic [3:0] code, input logic [31:0] restart, input string tag);
        item_t it;
        it.tk = 1; it.code = code; it.fpc = 32'(code) << 8; it.spc = restart;
        it.sst = m_st; it.st = m_st & 8'hFC; it.tag = tag;
        m_spc = restart; m_sst = m_st; m_st = it.st;
        exp_q.push_back(it);
    endtask

    task automatic push_rfi(input string tag);
        item_t it;
        it.tk = 0; it.code = 0; it.fpc = m_spc; it.spc = m_spc;
        it.sst = m_sst; it.st = m_sst; it.tag = tag;
        m_st = m_sst;
        exp_q.push_back(it);
    endtask

    task automatic retire(input logic [31:0] pc, input logic [31:0] npc, input logic [2:0] cause);
        ret_valid = 1; ret_pc = pc; ret_npc = npc; ret_cause = cause;
    endtask

    task automatic do_rfi();
        idle(); step();
        rfi = 1; push_rfi("R10 return");
        step();
        idle(); step();
    endtask

    // monitor: pops one expected item per observed flush
    always @(negedge clk) begin
        if (rst_n && flush) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected flush", {28'd0, take_code}, 32'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(take == e.tk, {e.tag, " take"}, {31'd0, take}, {31'd0, e.tk});
                if (e.tk) check(take_code == e.code, {e.tag, " code"}, {28'd0, take_code}, {28'd0, e.code});
                check(fetch_pc == e.fpc, {e.tag, " fetch_pc"}, fetch_pc, e.fpc);
                check(save_pc == e.spc, {e.tag, " save_pc"}, save_pc, e.spc);
                check(save_stat == e.sst, {e.tag, " save_stat"}, {24'd0, save_stat}, {24'd0, e.sst});
                check(status == e.st, {e.tag, " status"}, {24'd0, status}, {24'd0, e.st});
            end
        end
    end

    initial begin
        for (int n = 0; n < 5000; n++) @(posedge clk);
        check(0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        rst_n = 0; fp_mode = 0; resume_pc = 0;
        idle();
        m_st = 8'h03; m_sst = 0; m_spc = 0;
        repeat (3) step();
        check(status == 8'h03, "R1 reset status", {24'd0, status}, 32'h3);
        check(!flush && !take, "R1 reset flush/take", {30'd0, flush, take}, 32'd0);
        rst_n = 1;
        step();
        check(save_pc == 0 && save_stat == 0, "R1 save regs", save_pc, 32'd0);
        check(status == 8'h03 && !flush, "R1 after release", {24'd0, status}, 32'h3);

        // R5: held external interrupt waits for a boundary
        irq_ext = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            check(!flush, "R5 deferred while busy", {31'd0, flush}, 32'd0);
        end
        retire(32'h100, 32'h104, 3'd0);
        #0.5 check(commit, "R5 boundary instruction commits", {31'd0, commit}, 32'd1);
        push_take(4'd7, 32'h104, "R5 external at boundary");
        step();
        idle();
        do_rfi();

        // R3 fault, then R12 retire in flush cycle ignored
        retire(32'h200, 32'h204, 3'd1);
        #0.5 check(!commit, "R3 fault not committed", {31'd0, commit}, 32'd0);
        push_take(4'd3, 32'h200, "R3 fault");
        step();
        retire(32'h300, 32'h304, 3'd1);
        rfi = 1;
        #0.5 check(!commit, "R12 retire after flush ignored", {31'd0, commit}, 32'd0);
        step();
        idle();
        step();
        check(!flush, "R12 no second exception", {31'd0, flush}, 32'd0);
        do_rfi();

        // R4 trap and system call
        retire(32'h400, 32'h500, 3'd2);
        push_take(4'd4, 32'h500, "R4 trap");
        step(); idle(); do_rfi();
        retire(32'h600, 32'h604, 3'd3);
        push_take(4'd5, 32'h604, "R4 syscall");
        step(); idle(); do_rfi();

        // R11 floating-point with imprecise modes selected
        for (int m = 1; m < 4; m++) begin
            fp_mode = 2'(m);
            retire(32'h700 + 32'(m), 32'h800, 3'd4);
            #0.5 check(!commit, "R11 fp not committed", {31'd0, commit}, 32'd0);
            push_take(4'd6, 32'h700 + 32'(m), "R11 fp precise");
            step(); idle(); do_rfi();
        end
        fp_mode = 0;

        // R6 idle pipeline, R7 EE gating
        resume_pc = 32'h900;
        pipe_empty = 1; irq_dec = 1;
        push_take(4'd8, 32'h900, "R6 decrementer when idle");
        step();
        for (int k = 0; k < 4; k++) begin
            step();
            check(!flush, "R7 maskable blocked by EE=0", {31'd0, flush}, 32'd0);
        end
        rfi = 1; push_rfi("R10 return with pending irq");
        step();
        rfi = 0;
        step();
        push_take(4'd8, 32'h900, "R7 re-enabled decrementer");
        step();
        idle(); do_rfi();

        // R2 priority among maskables
        pipe_empty = 1; irq_smi = 1; irq_therm = 1; irq_perf = 1;
        push_take(4'd9, 32'h900, "R2 smi over therm/perf");
        step(); idle(); do_rfi();
        pipe_empty = 1; irq_perf = 1; irq_ext = 1; irq_dec = 1;
        push_take(4'd7, 32'h900, "R2 ext over dec/perf");
        step(); idle(); do_rfi();
        // R2 instruction fault beats external
        irq_ext = 1; retire(32'hA00, 32'hA04, 3'd1);
        push_take(4'd3, 32'hA00, "R2 fault over external");
        step(); idle(); do_rfi();
        // R2 reset beats machine check and fault; R7 held lines fire once
        nmi_reset = 1; nmi_mcheck = 1; retire(32'hB00, 32'hB04, 3'd1);
        push_take(4'd1, 32'hB00, "R2 reset highest");
        step();
        ret_valid = 0; ret_cause = 0;
        for (int k = 0; k < 3; k++) begin
            step();
            check(!flush, "R7 held nonmaskable taken once", {31'd0, flush}, 32'd0);
        end
        nmi_reset = 0; nmi_mcheck = 0;
        step();
        // R7 machine check while EE=0
        nmi_mcheck = 1;
        push_take(4'd2, 32'h900, "R7 mcheck with EE clear");
        step();
        idle(); step(); step();

        check(exp_q.size() == 0, "R9 all expected flushes seen", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule